// File: doc/BRIEF.md
# 64-bit Arithmetic, Logic and Shift Unit

This block is the integer execution unit of a small load/store core with 64-bit registers and 32-bit instructions. It is purely combinational. Each cycle it takes the instruction's opcode, its 5-bit source-register field, its low 16 bits, and the two register operands read for that instruction. It returns a 64-bit result and a flag that marks signed overflow on the checked add and subtract forms. The core decides what to do with the flag. Nothing in this block traps.

The opcode and function field are decoded locally. Register and immediate forms share one adder, one logic stage and one barrel shifter. Shifts run from 0 to 63 positions. The constant amount is built from bit 0 of the source-register field and bits 10:6 of the instruction. Variable shifts take their amount from the low six bits of the first operand. An encoding the unit does not serve gives a zero result with the flag low, so a stray instruction never produces a spurious overflow.

Top module: `alu64_top`

## Requirements
- R1: With `opcode`=000000 and function (imm_field[5:0]) 100000 or 100001, `result` = rs_val + rt_val modulo 2^64. With function 100010 or 100011, `result` = rs_val - rt_val modulo 2^64.
- R2: `overflow` is 1 only for function 100000 or 100010 under opcode 000000, or for opcode 001000, and only when the signed 64-bit sum or difference does not fit in 64 bits. It is 0 for every other encoding.
- R3: Function codes 100100, 100101, 100110 and 100111 give rs_val AND, OR, XOR and NOR rt_val respectively.
- R4: Function 101010 gives 1 when rs_val < rt_val as signed numbers and 0 otherwise. Function 101011 does the same compare on unsigned numbers. Bits 63:1 of the result are always 0.
- R5: Function codes 000000, 000010 and 000011 shift rt_val left logically, right logically and right arithmetically by {rs_field[0], imm_field[10:6]}. If rs_field[4:1] is non-zero, the result is 0.
- R6: Function codes 000100, 000110 and 000111 shift rt_val in the same three ways by rs_val[5:0]. Bits 63:6 of rs_val have no effect.
- R7: A shift by 0 returns rt_val unchanged. An arithmetic right shift by 63 returns 64 copies of rt_val[63].
- R8: Opcode 001000 (checked add) and opcode 001010 (signed compare) use imm_field sign-extended to 64 bits in place of rt_val.
- R9: Opcodes 001001 (add, no check), 001011 (unsigned compare), 001100 (AND), 001101 (OR) and 001110 (XOR) use imm_field zero-extended to 64 bits in place of rt_val.
- R10: Any other opcode, or any other function code under opcode 000000, gives `result` = 0 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Instruction bits 31:26 |
| rs_field | input | 5 | Instruction bits 25:21 (bit 0 is the high shift-amount bit) |
| imm_field | input | 16 | Instruction bits 15:0 (function code in 5:0, shift amount in 10:6) |
| rs_val | input | 64 | First register operand |
| rt_val | input | 64 | Second register operand, and the value that shifts act on |
| result | output | 64 | Operation result |
| overflow | output | 1 | Signed overflow of a checked add or subtract |

## Verification
The assertions assume all five inputs are settled, known values whenever they are evaluated. They also assume the register operands are independent of the instruction fields, so any operand pair may meet any encoding. The stimulus drives every input from the bench between clock edges, one vector at a time. It picks encodings from the legal lists, mixed with fully random codes, and picks operands from sign-boundary values as well as random ones. That mix lets the overflow, sign-extension and padding-bit rules all be reached without breaking those assumptions.

// File: rtl/alu64_pkg.sv
package alu64_pkg;
  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int RSF_W = 5;
  localparam int IMM_W = 16;
  localparam int CSH_LO_W = 5;

  localparam logic [OPC_W-1:0] OPC_REG    = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_ADDI   = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_ADDIU  = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_SLTI   = 6'b001010;
  localparam logic [OPC_W-1:0] OPC_SLTIU  = 6'b001011;
  localparam logic [OPC_W-1:0] OPC_ANDI   = 6'b001100;
  localparam logic [OPC_W-1:0] OPC_ORI    = 6'b001101;
  localparam logic [OPC_W-1:0] OPC_XORI   = 6'b001110;

  localparam logic [FN_W-1:0] FN_ADD  = 6'b100000;
  localparam logic [FN_W-1:0] FN_ADDU = 6'b100001;
  localparam logic [FN_W-1:0] FN_SUB  = 6'b100010;
  localparam logic [FN_W-1:0] FN_SUBU = 6'b100011;
  localparam logic [FN_W-1:0] FN_AND  = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR   = 6'b100101;
  localparam logic [FN_W-1:0] FN_XOR  = 6'b100110;
  localparam logic [FN_W-1:0] FN_NOR  = 6'b100111;
  localparam logic [FN_W-1:0] FN_SLT  = 6'b101010;
  localparam logic [FN_W-1:0] FN_SLTU = 6'b101011;
  localparam logic [FN_W-1:0] FN_SLL  = 6'b000000;
  localparam logic [FN_W-1:0] FN_SRL  = 6'b000010;
  localparam logic [FN_W-1:0] FN_SRA  = 6'b000011;
  localparam logic [FN_W-1:0] FN_SLLV = 6'b000100;
  localparam logic [FN_W-1:0] FN_SRLV = 6'b000110;
  localparam logic [FN_W-1:0] FN_SRAV = 6'b000111;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA
  } alu_op_e;

  typedef struct packed {
    alu_op_e op;
    logic    subtract;
    logic    chk_ovf;
    logic    use_imm;
    logic    imm_sext;
    logic    amt_from_reg;
  } alu_ctl_t;

  localparam alu_ctl_t CTL_IDLE = '{op: OP_NONE, subtract: 1'b0, chk_ovf: 1'b0,
                                    use_imm: 1'b0, imm_sext: 1'b0, amt_from_reg: 1'b0};
endpackage

// File: rtl/alu64_decode.sv
module alu64_decode
  import alu64_pkg::*;
#(
  parameter int SHAMT_W = 6
) (
  input  logic [OPC_W-1:0]   opcode,
  input  logic [RSF_W-1:0]   rs_field,
  input  logic [IMM_W-1:0]   imm_field,
  output alu_ctl_t           ctl,
  output logic [SHAMT_W-1:0] shamt_const
);
  logic [FN_W-1:0] fn;
  logic            pad_clear;

  assign fn          = imm_field[FN_W-1:0];
  assign pad_clear   = (rs_field[RSF_W-1:1] == '0);
  assign shamt_const = SHAMT_W'({rs_field[0], imm_field[FN_W+CSH_LO_W-1:FN_W]});

  function automatic alu_ctl_t reg_ctl(input alu_op_e op, input logic sub, input logic chk,
                                        input logic from_reg);
    alu_ctl_t c;
    c              = CTL_IDLE;
    c.op           = op;
    c.subtract     = sub;
    c.chk_ovf      = chk;
    c.amt_from_reg = from_reg;
    return c;
  endfunction

  function automatic alu_ctl_t imm_ctl(input alu_op_e op, input logic sub, input logic chk,
                                        input logic sext);
    alu_ctl_t c;
    c          = CTL_IDLE;
    c.op       = op;
    c.subtract = sub;
    c.chk_ovf  = chk;
    c.use_imm  = 1'b1;
    c.imm_sext = sext;
    return c;
  endfunction

  always_comb begin
    ctl = CTL_IDLE;
    unique case (opcode)
      OPC_REG: begin
        unique case (fn)
          FN_ADD:  ctl = reg_ctl(OP_ADD,  1'b0, 1'b1, 1'b0);
          FN_ADDU: ctl = reg_ctl(OP_ADD,  1'b0, 1'b0, 1'b0);
          FN_SUB:  ctl = reg_ctl(OP_SUB,  1'b1, 1'b1, 1'b0);
          FN_SUBU: ctl = reg_ctl(OP_SUB,  1'b1, 1'b0, 1'b0);
          FN_AND:  ctl = reg_ctl(OP_AND,  1'b0, 1'b0, 1'b0);
          FN_OR:   ctl = reg_ctl(OP_OR,   1'b0, 1'b0, 1'b0);
          FN_XOR:  ctl = reg_ctl(OP_XOR,  1'b0, 1'b0, 1'b0);
          FN_NOR:  ctl = reg_ctl(OP_NOR,  1'b0, 1'b0, 1'b0);
          FN_SLT:  ctl = reg_ctl(OP_SLT,  1'b1, 1'b0, 1'b0);
          FN_SLTU: ctl = reg_ctl(OP_SLTU, 1'b1, 1'b0, 1'b0);
          FN_SLL:  if (pad_clear) ctl = reg_ctl(OP_SLL, 1'b0, 1'b0, 1'b0);
          FN_SRL:  if (pad_clear) ctl = reg_ctl(OP_SRL, 1'b0, 1'b0, 1'b0);
          FN_SRA:  if (pad_clear) ctl = reg_ctl(OP_SRA, 1'b0, 1'b0, 1'b0);
          FN_SLLV: ctl = reg_ctl(OP_SLL,  1'b0, 1'b0, 1'b1);
          FN_SRLV: ctl = reg_ctl(OP_SRL,  1'b0, 1'b0, 1'b1);
          FN_SRAV: ctl = reg_ctl(OP_SRA,  1'b0, 1'b0, 1'b1);
          default: ctl = CTL_IDLE;
        endcase
      end
      OPC_ADDI:  ctl = imm_ctl(OP_ADD,  1'b0, 1'b1, 1'b1);
      OPC_ADDIU: ctl = imm_ctl(OP_ADD,  1'b0, 1'b0, 1'b0);
      OPC_SLTI:  ctl = imm_ctl(OP_SLT,  1'b1, 1'b0, 1'b1);
      OPC_SLTIU: ctl = imm_ctl(OP_SLTU, 1'b1, 1'b0, 1'b0);
      OPC_ANDI:  ctl = imm_ctl(OP_AND,  1'b0, 1'b0, 1'b0);
      OPC_ORI:   ctl = imm_ctl(OP_OR,   1'b0, 1'b0, 1'b0);
      OPC_XORI:  ctl = imm_ctl(OP_XOR,  1'b0, 1'b0, 1'b0);
      default:   ctl = CTL_IDLE;
    endcase
  end
endmodule

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
  parameter int DW = 64
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          subtract,
  output logic [DW-1:0] sum,
  output logic          ovf_raw,
  output logic          less_s,
  output logic          less_u
);
  localparam int MSB = DW - 1;

  logic [DW-1:0] b_eff;
  logic          carry_out;

  // Two same-signed addends whose sum changes sign have overflowed.
  function automatic logic sign_flip(input logic a_s, input logic b_s, input logic r_s);
    return (a_s == b_s) && (r_s != a_s);
  endfunction

  assign b_eff             = subtract ? ~op_b : op_b;
  assign {carry_out, sum}  = {1'b0, op_a} + {1'b0, b_eff} + {{DW{1'b0}}, subtract};
  assign ovf_raw           = sign_flip(op_a[MSB], b_eff[MSB], sum[MSB]);
  // With subtract set: signed less-than is the difference sign corrected by
  // overflow; unsigned less-than is a borrow (no carry out).
  assign less_s            = sum[MSB] ^ ovf_raw;
  assign less_u            = ~carry_out;
endmodule

// File: rtl/alu64_shifter.sv
module alu64_shifter #(
  parameter int DW      = 64,
  parameter int SHAMT_W = $clog2(DW)
) (
  input  logic [DW-1:0]      value,
  input  logic [SHAMT_W-1:0] amount,
  input  logic               go_left,
  input  logic               arith,
  output logic [DW-1:0]      shifted
);
  logic [DW-1:0] rev_in;
  logic [DW-1:0] rev_out;
  logic [DW-1:0] stage [0:SHAMT_W];
  logic          fill;

  // Left shifts reuse the right-shift network on a bit-reversed operand.
  for (genvar i = 0; i < DW; i++) begin : g_rev
    assign rev_in[i]  = value[DW-1-i];
    assign rev_out[i] = stage[SHAMT_W][DW-1-i];
  end

  assign fill     = arith & ~go_left & value[DW-1];
  assign stage[0] = go_left ? rev_in : value;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amount[k] ? {{STEP{fill}}, stage[k][DW-1:STEP]} : stage[k];
  end

  assign shifted = go_left ? rev_out : stage[SHAMT_W];
endmodule

// File: rtl/alu64_top.sv
module alu64_top
  import alu64_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic [5:0]    opcode,
  input  logic [4:0]    rs_field,
  input  logic [15:0]   imm_field,
  input  logic [DW-1:0] rs_val,
  input  logic [DW-1:0] rt_val,
  output logic [DW-1:0] result,
  output logic          overflow
);
  localparam int SHAMT_W = $clog2(DW);

  alu_ctl_t           ctl;
  logic [SHAMT_W-1:0] shamt_const;
  logic [SHAMT_W-1:0] shamt_sel;
  logic [DW-1:0]      imm_ext;
  logic [DW-1:0]      op_b;
  logic [DW-1:0]      sum;
  logic               ovf_raw;
  logic               less_s;
  logic               less_u;
  logic [DW-1:0]      sh_out;
  logic               arith_op;
  logic               ovf_event;

  function automatic logic [DW-1:0] widen_imm(input logic [IMM_W-1:0] imm, input logic sext);
    return sext ? {{(DW-IMM_W){imm[IMM_W-1]}}, imm} : {{(DW-IMM_W){1'b0}}, imm};
  endfunction

  function automatic logic [DW-1:0] flag_word(input logic bit_in);
    return {{(DW-1){1'b0}}, bit_in};
  endfunction

  alu64_decode #(.SHAMT_W(SHAMT_W)) i_decode (
    .opcode      (opcode),
    .rs_field    (rs_field),
    .imm_field   (imm_field),
    .ctl         (ctl),
    .shamt_const (shamt_const)
  );

  assign imm_ext   = widen_imm(imm_field, ctl.imm_sext);
  assign op_b      = ctl.use_imm ? imm_ext : rt_val;
  assign shamt_sel = ctl.amt_from_reg ? rs_val[SHAMT_W-1:0] : shamt_const;

  alu64_addsub #(.DW(DW)) i_addsub (
    .op_a     (rs_val),
    .op_b     (op_b),
    .subtract (ctl.subtract),
    .sum      (sum),
    .ovf_raw  (ovf_raw),
    .less_s   (less_s),
    .less_u   (less_u)
  );

  alu64_shifter #(.DW(DW), .SHAMT_W(SHAMT_W)) i_shifter (
    .value   (rt_val),
    .amount  (shamt_sel),
    .go_left (ctl.op == OP_SLL),
    .arith   (ctl.op == OP_SRA),
    .shifted (sh_out)
  );

  assign arith_op  = (ctl.op == OP_ADD) || (ctl.op == OP_SUB);
  assign ovf_event = ctl.chk_ovf & arith_op & ovf_raw;
  assign overflow  = ovf_event;

  always_comb begin
    unique case (ctl.op)
      OP_ADD, OP_SUB:         result = sum;
      OP_AND:                 result = rs_val & op_b;
      OP_OR:                  result = rs_val | op_b;
      OP_XOR:                 result = rs_val ^ op_b;
      OP_NOR:                 result = ~(rs_val | op_b);
      OP_SLT:                 result = flag_word(less_s);
      OP_SLTU:                result = flag_word(less_u);
      OP_SLL, OP_SRL, OP_SRA: result = sh_out;
      default:                result = '0;
    endcase
  end
endmodule

// File: rtl/alu64_checker.sv
module alu64_checker #(
  parameter int DW = 64
) (
  input logic [5:0]    opcode,
  input logic [4:0]    rs_field,
  input logic [15:0]   imm_field,
  input logic [DW-1:0] rs_val,
  input logic [DW-1:0] rt_val,
  input logic [DW-1:0] result,
  input logic          overflow
);
  localparam int SW = $clog2(DW);

  logic [5:0]    fn;
  logic          is_reg;
  logic          checked;
  logic          is_cmp;
  logic          is_logic;
  logic          is_shift;
  logic          legal;
  logic [SW-1:0] amt;
  logic          known;

  always_comb begin
    fn       = imm_field[5:0];
    is_reg   = (opcode == 6'b000000);
    checked  = (is_reg && (fn == 6'b100000 || fn == 6'b100010)) || opcode == 6'b001000;
    is_cmp   = (is_reg && (fn == 6'b101010 || fn == 6'b101011)) ||
               opcode == 6'b001010 || opcode == 6'b001011;
    is_logic = (is_reg && fn[5:2] == 4'b1001) ||
               opcode == 6'b001100 || opcode == 6'b001101 || opcode == 6'b001110;
    is_shift = is_reg && fn[5:3] == 3'b000 && fn[1:0] != 2'b01 &&
               (fn[2] || rs_field[4:1] == 4'b0000);
    legal    = is_shift || (is_reg && fn[5:3] == 3'b100) || is_cmp ||
               (opcode[5:3] == 3'b001 && opcode[2:0] != 3'b111);
    amt      = fn[2] ? rs_val[SW-1:0] : SW'({rs_field[0], imm_field[10:6]});
    known    = !$isunknown({opcode, rs_field, imm_field, rs_val, rt_val});
  end

  always_comb begin
    if (known) begin
      if (overflow) begin
        p_ovf_checked_only_r2: assert (checked)
          else $error("overflow raised for an unchecked encoding");
      end
      if (overflow && is_reg && fn == 6'b100000) begin
        p_ovf_sign_rule_r2: assert (rs_val[DW-1] == rt_val[DW-1] && result[DW-1] != rs_val[DW-1])
          else $error("overflow without a sign flip");
      end
      if (is_logic) begin
        p_logic_no_ovf_r3: assert (!overflow)
          else $error("logic op raised overflow");
      end
      if (is_cmp) begin
        p_cmp_boolean_r4: assert (result[DW-1:1] == '0 && !overflow)
          else $error("compare result not 0 or 1");
      end
      if (is_shift && amt == '0) begin
        p_shift_zero_pass_r7: assert (result == rt_val)
          else $error("zero shift altered operand");
      end
      if (is_shift && fn[1:0] == 2'b11 && amt == SW'(DW-1)) begin
        p_sra_full_fill_r7: assert (result == {DW{rt_val[DW-1]}})
          else $error("full arithmetic shift not all sign bits");
      end
      if (opcode == 6'b001101) begin
        p_ori_zext_r9: assert (result == (rs_val | {{(DW-16){1'b0}}, imm_field}))
          else $error("ori immediate not zero-extended");
      end
      if (!legal) begin
        p_illegal_quiet_r10: assert (result == '0 && !overflow)
          else $error("unserved encoding gave non-zero output");
      end
    end
  end
endmodule

bind alu64_top alu64_checker #(.DW(DW)) i_chk (
  .opcode    (opcode),
  .rs_field  (rs_field),
  .imm_field (imm_field),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .result    (result),
  .overflow  (overflow)
);

// File: tb/test_alu64_top.sv
module test_alu64_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  opcode = '0;
  logic [4:0]  rs_field = '0;
  logic [15:0] imm_field = '0;
  logic [63:0] rs_val = '0;
  logic [63:0] rt_val = '0;
  logic [63:0] result;
  logic        overflow;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2 clk = ~clk;

  alu64_top i_alu64_top (
    .opcode(opcode), .rs_field(rs_field), .imm_field(imm_field),
    .rs_val(rs_val), .rt_val(rt_val), .result(result), .overflow(overflow)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cycles);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // Returns {overflow, result} computed from the requirements.
  function automatic logic [64:0] model(input logic [5:0] opc, input logic [4:0] rsf,
                                        input logic [15:0] imf, input logic [63:0] a,
                                        input logic [63:0] b);
    logic [63:0] sx, zx, r;
    logic [5:0]  csh, vsh;
    logic [64:0] w;
    logic        v;
    sx  = {{48{imf[15]}}, imf};
    zx  = {48'd0, imf};
    csh = {rsf[0], imf[10:6]};
    vsh = a[5:0];
    r   = '0;
    v   = 1'b0;
    if (opc == 6'h00) begin
      case (imf[5:0])
        6'h20: begin w = {a[63], a} + {b[63], b}; r = w[63:0]; v = w[64] ^ w[63]; end
        6'h21: r = a + b;
        6'h22: begin w = {a[63], a} - {b[63], b}; r = w[63:0]; v = w[64] ^ w[63]; end
        6'h23: r = a - b;
        6'h24: r = a & b;
        6'h25: r = a | b;
        6'h26: r = a ^ b;
        6'h27: r = ~(a | b);
        6'h2A: r = ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
        6'h2B: r = (a < b) ? 64'd1 : 64'd0;
        6'h00: if (rsf[4:1] == 4'd0) r = b << csh;
        6'h02: if (rsf[4:1] == 4'd0) r = b >> csh;
        6'h03: if (rsf[4:1] == 4'd0) r = $signed(b) >>> csh;
        6'h04: r = b << vsh;
        6'h06: r = b >> vsh;
        6'h07: r = $signed(b) >>> vsh;
        default: r = '0;
      endcase
    end else begin
      case (opc)
        6'h08: begin w = {a[63], a} + {sx[63], sx}; r = w[63:0]; v = w[64] ^ w[63]; end
        6'h09: r = a + zx;
        6'h0A: r = ($signed(a) < $signed(sx)) ? 64'd1 : 64'd0;
        6'h0B: r = (a < zx) ? 64'd1 : 64'd0;
        6'h0C: r = a & zx;
        6'h0D: r = a | zx;
        6'h0E: r = a ^ zx;
        default: r = '0;
      endcase
    end
    return {v, r};
  endfunction

  function automatic string tag_of(input logic [5:0] opc, input logic [4:0] rsf,
                                   input logic [5:0] fn);
    if (opc == 6'h00) begin
      case (fn)
        6'h20, 6'h21, 6'h22, 6'h23: return "R1";
        6'h24, 6'h25, 6'h26, 6'h27: return "R3";
        6'h2A, 6'h2B:               return "R4";
        6'h00, 6'h02, 6'h03:        return (rsf[4:1] != 0) ? "R10" : "R5";
        6'h04, 6'h06, 6'h07:        return "R6";
        default:                    return "R10";
      endcase
    end
    if (opc == 6'h08 || opc == 6'h0A) return "R8";
    if (opc == 6'h09 || (opc >= 6'h0B && opc <= 6'h0E)) return "R9";
    return "R10";
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (opc %h rs_f %h imm %h rs %h rt %h)",
               tag, got, exp, opcode, rs_field, imm_field, rs_val, rt_val);
    end
  endtask

  // Drive at the falling edge, check 1 ns later (combinational path).
  task automatic apply(input logic [5:0] opc, input logic [4:0] rsf, input logic [15:0] imf,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [64:0] exp;
    @(negedge clk);
    opcode = opc; rs_field = rsf; imm_field = imf; rs_val = a; rt_val = b;
    #1;
    exp = model(opc, rsf, imf, a, b);
    check(tag, result, exp[63:0]);
    check("R2", {63'd0, overflow}, {63'd0, exp[64]});
  endtask

  function automatic logic [63:0] pick_operand();
    case ($urandom % 7)
      0: return 64'd0;
      1: return 64'h7FFF_FFFF_FFFF_FFFF;
      2: return 64'h8000_0000_0000_0000;
      3: return '1;
      4: return {32'd0, 16'd0, 16'($urandom)};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  logic [5:0] fn_list [16] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26, 6'h27,
                               6'h2A, 6'h2B, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
  logic [5:0] imm_ops [7]  = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E};

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Quiescent inputs: shift-left by 0 of zero gives zero, no flag (R7).
    #1;
    check("R7", result, 64'd0);
    check("R2", {63'd0, overflow}, 64'd0);

    // Directed corners.
    apply(6'h00, 5'd0, 16'h0020, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R2");
    apply(6'h00, 5'd0, 16'h0021, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, "R1");
    apply(6'h00, 5'd0, 16'h0022, 64'h8000_0000_0000_0000, 64'd1, "R2");
    apply(6'h00, 5'd0, 16'h0023, 64'h8000_0000_0000_0000, 64'd1, "R1");
    apply(6'h00, 5'd0, 16'h0022, 64'd0, 64'h8000_0000_0000_0000, "R2");
    apply(6'h00, 5'd0, 16'h002A, '1, 64'd1, "R4");
    apply(6'h00, 5'd0, 16'h002B, '1, 64'd1, "R4");
    apply(6'h00, 5'd0, 16'h0027, 64'h0F0F, 64'hF000, "R3");
    apply(6'h00, 5'd1, 16'h07C0, 64'd0, 64'd1, "R5");              // sll by 63
    apply(6'h00, 5'd1, 16'h07C3, 64'd0, 64'h8000_0000_0000_0000, "R7"); // sra by 63
    apply(6'h00, 5'd1, 16'h07C3, 64'd0, 64'h4000_0000_0000_0000, "R7");
    apply(6'h00, 5'd0, 16'h0002, 64'd0, 64'hDEAD_BEEF_0123_4567, "R7"); // shift 0
    apply(6'h00, 5'd0, 16'h0007, 64'hFFFF_FFFF_FFFF_FFC4, 64'h8000_0000_0000_0000, "R6");
    apply(6'h00, 5'd0, 16'h0004, 64'hABCD_0000_0000_0040, 64'h1234, "R6");
    apply(6'h00, 5'd4, 16'h0040, 64'd0, 64'd1, "R10");             // padding bit set
    apply(6'h00, 5'd0, 16'h0008, 64'h1000, 64'h1, "R10");          // unserved function
    apply(6'h23, 5'd0, 16'h1234, 64'h55, 64'h66, "R10");           // unserved opcode
    apply(6'h08, 5'd0, 16'hFFFF, 64'd5, 64'd0, "R8");
    apply(6'h08, 5'd0, 16'h0001, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, "R8");
    apply(6'h0A, 5'd0, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFE, 64'd0, "R8");
    apply(6'h09, 5'd0, 16'hFFFF, 64'd1, 64'd0, "R9");
    apply(6'h0B, 5'd0, 16'h8000, 64'h7FFF, 64'd0, "R9");
    apply(6'h0C, 5'd0, 16'hF00F, '1, 64'd0, "R9");
    apply(6'h0E, 5'd0, 16'h8001, '1, 64'd0, "R9");

    // Constrained random sweep.
    for (int n = 0; n < 3000; n++) begin
      logic [5:0]  opc;
      logic [4:0]  rsf;
      logic [15:0] imf;
      int          kind;
      kind = int'($urandom % 10);
      imf  = 16'($urandom);
      rsf  = 5'($urandom);
      if (kind < 6) begin
        opc = 6'h00;
        imf[5:0] = fn_list[$urandom % 16];
        if (($urandom % 4) != 0) rsf[4:1] = 4'd0;
      end else if (kind < 9) begin
        opc = imm_ops[$urandom % 7];
      end else begin
        opc = 6'($urandom);
      end
      apply(opc, rsf, imf, pick_operand(), pick_operand(), tag_of(opc, rsf, imf[5:0]));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule